// File: doc/BRIEF.md
# Permutation Spare-Unit Reconfiguration Cluster

The cluster holds eight identical small arithmetic units and offers six functional lanes to the logic around it. Each lane carries two 4-bit operands and returns their 5-bit sum (carry and sum bits). The cluster never assigns a fixed spare to any unit. Instead, a registered 2-bit configuration state rotates one adjacent pair of units out of service. The six lanes then slide onto the six remaining units in ascending order. The whole routing network is built from two-way selectors.

The two units taken out of service have their operand inputs forced to zero. Their outputs reach only two observation ports, so a defective unit cannot disturb any lane. An input short inside such a unit is harmless for the same reason. A built-in repair advisor takes a mask of units known to be bad. It returns the state that removes all of them, or it flags the set as beyond repair. Any single failure can be repaired, and so can a double failure that falls within one pair. A fault-injection mask inverts the output of chosen units, so a bench can model defects.

Top module: `spare_perm_cluster`

## Requirements
- R1: A synchronous active-low reset sets the configuration state to 0, and cur_state reads 0 after it.
- R2: When cfg_load is 1 at a rising edge, the state takes cfg_value from that edge on. When cfg_load is 0, the state holds, whatever cfg_value shows.
- R3: Each unit returns the 5-bit value {carry, sum} of its two 4-bit operands, so 4'hF + 4'h1 gives 5'h10 and 4'hF + 4'hF gives 5'h1E.
- R4: In state k, lane i (operands in bits [4i+3:4i] of lane_a and lane_b, result in bits [5i+4:5i] of lane_y) is served by unit i when i < 2k and by unit i+2 otherwise. With no faults injected, every lane returns the sum of its own operands.
- R5: In state k, units 2k and 2k+1 receive zero operands. obs_y bits [4:0] carry the output of unit 2k and bits [9:5] carry the output of unit 2k+1, so both read 0 when those units are healthy.
- R6: Setting bit u of flt_mask inverts all five output bits of unit u. A fault on a unit that is out of service changes only obs_y. A fault on a unit in service inverts the lane that unit serves.
- R7: The advisor returns fix_ok = 1 with fix_state = 0 for an empty fail_mask. For exactly one bad unit u, it returns fix_ok = 1 with fix_state = u/2, rounded down.
- R8: When both units of pair p are bad and no other unit is, the advisor returns fix_ok = 1 and fix_state = p. Every other fail_mask with two or more bits set gives fix_ok = 0 and fix_state = 0.
- R9: Lane and observation outputs follow their inputs within the same cycle, with no register on the path, and are routed by the current registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load strobe for the configuration state |
| cfg_value | input | 2 | State to load; state k removes units 2k and 2k+1 |
| cur_state | output | 2 | Current registered configuration state |
| lane_a | input | 24 | First operand of each lane, 4 bits per lane |
| lane_b | input | 24 | Second operand of each lane, 4 bits per lane |
| lane_y | output | 30 | Result of each lane, 5 bits per lane |
| obs_y | output | 10 | Outputs of the two removed units, lower unit first |
| flt_mask | input | 8 | Test-only fault injection, one bit per unit |
| fail_mask | input | 8 | Units known to be bad, one bit per unit |
| fix_state | output | 2 | Advised state that removes every bad unit |
| fix_ok | output | 1 | 1 when the bad set can be removed by some state |

## Verification
The checks on lane sums and on quiet observation ports assume that no fault is injected, so they are armed only while flt_mask is all zero. The stimulus injects faults only in dedicated cycles that the scoreboard models explicitly. The load and hold checks assume that cfg_load and cfg_value stay steady across each rising edge. The bench changes every input only at the falling edge, and it reloads the state in its own cycles, during which no result is sampled. The advisor checks take any fail_mask, and the stimulus sweeps all 256 of them.

// File: rtl/psr_pkg.sv
package psr_pkg;

    // Default geometry: number of unit pairs and operand width
    localparam int PSR_PAIRS = 4;
    localparam int PSR_W     = 4;

endpackage

// File: rtl/psr_switch2.sv
// psr_switch2: two-way selector, the only switching element of the cluster.
// Assumes: sel is a settled level; position 0 passes in0, position 1 passes in1.
module psr_switch2 #(
    parameter int W = 4
) (
    input  logic         sel,
    input  logic [W-1:0] in0,
    input  logic [W-1:0] in1,
    output logic [W-1:0] y
);

    // Select between the two positions
    always_comb begin
        y = sel ? in1 : in0;
    end

endmodule

// File: rtl/psr_unit.sv
// psr_unit: one replaceable logic unit, a W-bit adder with carry out.
// Assumes: inv is a test-only defect model that inverts the whole result.
module psr_unit #(
    parameter int W = 4
) (
    input  logic         inv,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W:0]   y
);

    logic [W:0] sum;

    // Unit function: zero-extended add
    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
    end

    // Defect model: invert every output bit when injected
    always_comb begin
        y = sum ^ {(W+1){inv}};
    end

endmodule

// File: rtl/psr_cfg.sv
// psr_cfg: registered configuration state of the cluster.
// Assumes: cfg_value lies in 0..PAIRS-1; the state changes only on a load.
module psr_cfg #(
    parameter int SW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [SW-1:0] cfg_value,
    output logic [SW-1:0] state
);

    // State register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (cfg_load) begin
            state <= cfg_value;
        end
    end

    // R1: state is zero in the first cycle after reset
    p_rst_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> state == '0);

    // R2: a load takes effect on the next edge
    p_load_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> state == $past(cfg_value));

    // R2: without a load the state holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(state));

endmodule

// File: rtl/psr_advisor.sv
// psr_advisor: picks the state whose removed pair covers every bad unit.
// Assumes: fail_mask marks bad units, one bit per unit; the result is combinational.
module psr_advisor #(
    parameter int PAIRS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*PAIRS-1:0]       fail_mask,
    output logic [$clog2(PAIRS)-1:0] fix_state,
    output logic                     fix_ok
);

    localparam int UNITS = 2 * PAIRS;
    localparam int SW    = $clog2(PAIRS);

    logic [PAIRS-1:0] pair_hit;
    int               hits;
    int               first;

    // Mark each pair that holds at least one bad unit
    always_comb begin
        for (int p = 0; p < PAIRS; p++) begin
            pair_hit[p] = fail_mask[2*p] | fail_mask[2*p+1];
        end
    end

    // Count hit pairs and find the lowest one
    always_comb begin
        hits  = 0;
        first = 0;
        for (int p = PAIRS - 1; p >= 0; p--) begin
            if (pair_hit[p]) begin
                hits  = hits + 1;
                first = p;
            end
        end
    end

    // Repairable only when all bad units sit in one pair
    always_comb begin
        fix_ok    = (hits <= 1);
        fix_state = (hits == 1) ? SW'(first) : '0;
    end

    // R7: an advised state leaves no bad unit in service
    p_ok_covers_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fix_ok |-> (fail_mask & ~(UNITS'(3) << (2 * fix_state))) == '0);

    // R8: a refused set has at least two bad units and advises state 0
    p_bad_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fix_ok |-> ($countones(fail_mask) >= 2 && fix_state == '0));

endmodule

// File: rtl/psr_xbar.sv
// psr_xbar: two-way switch network between the lanes and the units.
// Assumes: state k takes units 2k and 2k+1 out; lanes fill the rest in
// ascending order; removed units get zero operands and feed the observers.
module psr_xbar #(
    parameter int PAIRS = 4,
    parameter int W     = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(PAIRS)-1:0]          state,
    input  logic [2*PAIRS-3:0][W-1:0]         lane_a,
    input  logic [2*PAIRS-3:0][W-1:0]         lane_b,
    input  logic [2*PAIRS-1:0][W:0]           unit_y,
    output logic [2*PAIRS-1:0][W-1:0]         unit_a,
    output logic [2*PAIRS-1:0][W-1:0]         unit_b,
    output logic [2*PAIRS-3:0][W:0]           lane_y,
    output logic [1:0][W:0]                   obs_y
);

    localparam int UNITS = 2 * PAIRS;
    localparam int LANES = UNITS - 2;

    // Input side: each unit picks lane u or lane u-2, then the isolation switch
    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        localparam int P = u / 2;
        logic         pick_hi;
        logic         iso;
        logic [W-1:0] lo_a, lo_b, hi_a, hi_b, mid_a, mid_b;

        assign pick_hi = (int'(state) < P);
        assign iso     = (int'(state) == P);

        if (u < LANES) begin : g_lo
            assign lo_a = lane_a[u];
            assign lo_b = lane_b[u];
        end else begin : g_lo_none
            assign lo_a = '0;
            assign lo_b = '0;
        end

        if (u >= 2) begin : g_hi
            assign hi_a = lane_a[u-2];
            assign hi_b = lane_b[u-2];
        end else begin : g_hi_none
            assign hi_a = '0;
            assign hi_b = '0;
        end

        psr_switch2 #(.W(2*W)) u_shift (
            .sel (pick_hi),
            .in0 ({lo_a, lo_b}),
            .in1 ({hi_a, hi_b}),
            .y   ({mid_a, mid_b})
        );

        psr_switch2 #(.W(2*W)) u_iso (
            .sel (iso),
            .in0 ({mid_a, mid_b}),
            .in1 ({(2*W){1'b0}}),
            .y   ({unit_a[u], unit_b[u]})
        );

        // R5: a removed unit sees only zero operands
        p_iso_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(state) == P) |-> (unit_a[u] == '0 && unit_b[u] == '0));
    end

    // Output side: lane i takes unit i below the removed pair, else unit i+2
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic take_hi;
        assign take_hi = (int'(state) <= i / 2);

        psr_switch2 #(.W(W+1)) u_out (
            .sel (take_hi),
            .in0 (unit_y[i]),
            .in1 (unit_y[i+2]),
            .y   (lane_y[i])
        );
    end

    // Observation side: the removed pair drives the two extra ports
    always_comb begin
        for (int j = 0; j < 2; j++) begin
            obs_y[j] = unit_y[2 * int'(state) + j];
        end
    end

endmodule

// File: rtl/spare_perm_cluster.sv
// spare_perm_cluster: eight adder units behind a permutation switch network,
// six in service, one adjacent pair out, plus a repair advisor.
// Assumes: flt_mask is used only by a test bench; ports are flat vectors
// with lane i at slice i of each bus.
module spare_perm_cluster #(
    parameter int PAIRS = psr_pkg::PSR_PAIRS,
    parameter int W     = psr_pkg::PSR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cfg_load,
    input  logic [$clog2(PAIRS)-1:0]         cfg_value,
    output logic [$clog2(PAIRS)-1:0]         cur_state,
    input  logic [(2*PAIRS-2)*W-1:0]         lane_a,
    input  logic [(2*PAIRS-2)*W-1:0]         lane_b,
    output logic [(2*PAIRS-2)*(W+1)-1:0]     lane_y,
    output logic [2*(W+1)-1:0]               obs_y,
    input  logic [2*PAIRS-1:0]               flt_mask,
    input  logic [2*PAIRS-1:0]               fail_mask,
    output logic [$clog2(PAIRS)-1:0]         fix_state,
    output logic                             fix_ok
);

    localparam int UNITS = 2 * PAIRS;
    localparam int LANES = UNITS - 2;
    localparam int SW    = $clog2(PAIRS);
    localparam int YW    = W + 1;

    logic [SW-1:0]              state;
    logic [LANES-1:0][W-1:0]    la, lb;
    logic [LANES-1:0][W:0]      ly;
    logic [UNITS-1:0][W-1:0]    ua, ub;
    logic [UNITS-1:0][W:0]      uy;
    logic [1:0][W:0]            oy;

    // Unpack lane operands and repack lane results
    for (genvar i = 0; i < LANES; i++) begin : g_pack
        assign la[i] = lane_a[i*W +: W];
        assign lb[i] = lane_b[i*W +: W];
        assign lane_y[i*YW +: YW] = ly[i];

        // R4: with no fault injected, each lane returns its own sum
        p_lane_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_mask == '0) |-> lane_y[i*YW +: YW] ==
                ({1'b0, lane_a[i*W +: W]} + {1'b0, lane_b[i*W +: W]}));
    end

    assign obs_y     = {oy[1], oy[0]};
    assign cur_state = state;

    // R5: healthy removed units read zero on the observers
    p_obs_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_mask == '0) |-> obs_y == '0);

    psr_cfg #(.SW(SW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_load  (cfg_load),
        .cfg_value (cfg_value),
        .state     (state)
    );

    psr_xbar #(.PAIRS(PAIRS), .W(W)) u_xbar (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .lane_a (la),
        .lane_b (lb),
        .unit_y (uy),
        .unit_a (ua),
        .unit_b (ub),
        .lane_y (ly),
        .obs_y  (oy)
    );

    for (genvar u = 0; u < UNITS; u++) begin : g_units
        psr_unit #(.W(W)) u_unit (
            .inv (flt_mask[u]),
            .a   (ua[u]),
            .b   (ub[u]),
            .y   (uy[u])
        );
    end

    psr_advisor #(.PAIRS(PAIRS)) u_adv (
        .clk       (clk),
        .rst_n     (rst_n),
        .fail_mask (fail_mask),
        .fix_state (fix_state),
        .fix_ok    (fix_ok)
    );

endmodule

// File: tb/spare_perm_cluster_tb.sv
`timescale 1ns/1ps
module spare_perm_cluster_tb;

    localparam int LANES = 6;
    localparam int W     = 4;
    localparam int YW    = 5;
    localparam int LW    = LANES * W;
    localparam int LY    = LANES * YW;

    typedef struct packed {
        logic [LY-1:0]   ly;
        logic [2*YW-1:0] oy;
        logic [1:0]      st;
        logic [1:0]      fs;
        logic            fo;
        logic            rchk;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_load;
    logic [1:0]    cfg_value;
    logic [1:0]    cur_state;
    logic [LW-1:0] lane_a, lane_b;
    logic [LY-1:0] lane_y;
    logic [2*YW-1:0] obs_y;
    logic [7:0]    flt_mask, fail_mask;
    logic [1:0]    fix_state;
    logic          fix_ok;

    item_t q[$];
    string qt[$];
    int    n_checks = 0;
    int    n_errors = 0;
    int    model_k  = 0;
    bit    done     = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    spare_perm_cluster u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_value (cfg_value),
        .cur_state (cur_state), .lane_a (lane_a), .lane_b (lane_b), .lane_y (lane_y),
        .obs_y (obs_y), .flt_mask (flt_mask), .fail_mask (fail_mask),
        .fix_state (fix_state), .fix_ok (fix_ok)
    );

    // Serving unit of a lane per the lane mapping rule
    function automatic logic [LY-1:0] exp_lanes(logic [LW-1:0] a, logic [LW-1:0] b,
                                                logic [7:0] flt, int k);
        logic [LY-1:0] r;
        for (int i = 0; i < LANES; i++) begin
            int u;
            logic [YW-1:0] s;
            u = (i < 2 * k) ? i : i + 2;
            s = {1'b0, a[i*W +: W]} + {1'b0, b[i*W +: W]};
            if (flt[u]) s = ~s;
            r[i*YW +: YW] = s;
        end
        return r;
    endfunction

    function automatic logic [2*YW-1:0] exp_obs(logic [7:0] flt, int k);
        logic [2*YW-1:0] r;
        for (int j = 0; j < 2; j++) begin
            r[j*YW +: YW] = flt[2*k+j] ? {YW{1'b1}} : '0;
        end
        return r;
    endfunction

    // Lowest pair that contains every bad unit; none means beyond repair
    function automatic logic [2:0] exp_fix(logic [7:0] fail);
        for (int p = 0; p < 4; p++) begin
            logic [7:0] keep;
            keep = 8'b0;
            keep[2*p] = 1'b1;
            keep[2*p+1] = 1'b1;
            if ((fail & ~keep) == 8'b0) return {1'b1, 2'(p)};
        end
        return 3'b000;
    endfunction

    task automatic next_rand(output logic [31:0] v);
        seed = seed * 32'd1103515245 + 32'd12345;
        v = seed;
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Driver: apply one pattern and push its expected results
    task automatic apply(input logic [LW-1:0] a, input logic [LW-1:0] b,
                         input logic [7:0] flt, input logic [7:0] fail,
                         input string tl, input bit rchk);
        item_t e;
        logic [2:0] fx;
        @(negedge clk);
        lane_a = a; lane_b = b; flt_mask = flt; fail_mask = fail;
        fx = exp_fix(fail);
        e.ly = exp_lanes(a, b, flt, model_k);
        e.oy = exp_obs(flt, model_k);
        e.st = 2'(model_k);
        e.fs = fx[1:0];
        e.fo = fx[2];
        e.rchk = rchk;
        q.push_back(e);
        qt.push_back(tl);
    endtask

    task automatic apply_rnd(input logic [7:0] flt, input logic [7:0] fail,
                             input string tl);
        logic [31:0] r1, r2;
        next_rand(r1);
        next_rand(r2);
        apply(r1[LW-1:0], r2[LW-1:0], flt, fail, tl, 1'b0);
    endtask

    task automatic load(input int k);
        @(negedge clk);
        cfg_load = 1'b1;
        cfg_value = 2'(k);
        @(negedge clk);
        cfg_load = 1'b0;
        model_k = k;
    endtask

    // Monitor: pop and compare before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                item_t e;
                string t;
                string ft;
                e = q.pop_front();
                t = qt.pop_front();
                ft = e.fo ? "R7/R8" : "R8";
                chk(lane_y == e.ly, t, "lane_y", 64'(lane_y), 64'(e.ly));
                chk(obs_y == e.oy, (t == "R4") ? "R5" : t, "obs_y", 64'(obs_y), 64'(e.oy));
                chk(cur_state == e.st, e.rchk ? "R1" : "R2", "cur_state",
                    64'(cur_state), 64'(e.st));
                chk(fix_ok == e.fo, ft, "fix_ok", 64'(fix_ok), 64'(e.fo));
                chk(fix_state == e.fs, ft, "fix_state", 64'(fix_state), 64'(e.fs));
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0; cfg_value = 2'd0;
        lane_a = '0; lane_b = '0; flt_mask = '0; fail_mask = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, checked with a plain pattern
        apply(24'h12_3456, 24'h65_4321, 8'h00, 8'h00, "R4", 1'b1);

        // R4, R5, R6: every state, healthy and faulty units
        for (int k = 0; k < 4; k++) begin
            load(k);
            for (int n = 0; n < 3; n++) apply_rnd(8'h00, 8'h00, "R4");
            apply_rnd(8'h01 << (2*k), 8'h00, "R6");
            apply_rnd(8'h01 << (2*k + 1), 8'h00, "R6");
            apply_rnd(8'h01 << ((2*k + 2) % 8), 8'h00, "R6");
            apply_rnd(8'hFF, 8'h00, "R6");
        end

        // R3: carry corner cases
        load(0);
        apply({LANES{4'hF}}, {LANES{4'h1}}, 8'h00, 8'h00, "R3", 1'b0);
        apply({LANES{4'hF}}, {LANES{4'hF}}, 8'h00, 8'h00, "R3", 1'b0);
        apply('0, '0, 8'h00, 8'h00, "R3", 1'b0);

        // R2: cfg_value changes without a load strobe
        load(3);
        @(negedge clk);
        cfg_value = 2'd1;
        repeat (2) @(negedge clk);
        apply_rnd(8'h00, 8'h00, "R2");

        // R9: outputs follow inputs with no clock edge in between
        apply_rnd(8'h00, 8'h00, "R9");
        apply_rnd(8'h00, 8'h00, "R9");

        // R7, R8: advisor over every fail mask
        load(1);
        for (int m = 0; m < 256; m++) apply_rnd(8'h00, 8'(m), "R4");

        wait (q.size() == 0);
        @(negedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule